// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the device side of a 256-byte, byte-wide serial EEPROM on a two-wire bus. Both bus lines reach it as raw inputs. It samples them on the system clock through two-stage synchronizers and finds bus edges from the synchronized values. It pulls SDA low through an open-drain enable output and never drives it high. It recognizes bus start and stop conditions and checks the device address byte against a fixed family code and three strap pins. It then either receives a word address and a burst of page data, or sends bytes from its internal address counter.

Write data is collected in an 8-entry page buffer. Only the low three address bits advance during a burst, so a burst wraps inside its aligned page. The buffer is copied into the array when a stop condition ends the burst, and that stop also starts an internal write-cycle timer. Until the timer expires, every device address is refused. A read sends data from the counter and advances it after each byte. The read goes on for as long as the master acknowledges. A write that sets only the address, followed by a repeated start, gives a random read.

Top module: `twowire_eeprom`

## Requirements
- R1: With SCL high, a falling SDA edge is a start and puts the block in its device-address phase; a rising SDA edge is a stop, which returns the block to idle with SDA released.
- R2: The device address byte is received MSB first. It is acknowledged (SDA held low through the ninth SCL pulse) only when bits 7..4 are 1010 and bits 3..1 equal the strap inputs; bit 0 set to 1 selects a read. On a mismatch the block does not acknowledge and ignores all bytes until the next start.
- R3: In a write, the block acknowledges the word address byte and every data byte; a stop commits the buffered bytes to the array.
- R4: Each data byte goes to page slot address[2:0], and only those three bits increment, so a burst wraps within its aligned 8-byte page; bytes past the eighth overwrite the earliest ones.
- R5: A stop that commits data starts a write-cycle timer of WC_CYCLES clocks; while it runs no device address is acknowledged, and after it expires addresses are acknowledged again.
- R6: A read sends the byte at the current address counter MSB first, incrementing the counter after each byte, and sends further bytes while the master acknowledges.
- R7: A master non-acknowledge ends a read with SDA released; the counter then points one past the last byte sent, wrapping from 255 to 0.
- R8: After a write, the counter points one past the last byte written, wrapped within the page.
- R9: A start in the middle of a transfer aborts it and discards uncommitted page data; a later stop writes nothing.
- R10: During and after reset, SDA is released and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| cs_strap | input | 3 | Chip-select straps compared with device address bits 3..1 |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |

## Verification
The bench sends a burst of ten bytes. A design that stored the burst linearly would spill into the next page, and one that dropped the overflow would keep the two oldest bytes. The bench then reads back the whole page and the current address. It reads across address 255, where a counter that wrapped within the page would return the wrong byte. It also issues a start in the middle of a byte, after two data bytes were buffered. A design that kept those bytes would commit them at the next stop. It addresses the block right after a commit, where a missing busy window shows up as an acknowledge, and it checks that a refused address leaves every later byte unacknowledged.

// File: rtl/twowire_eeprom.sv
module twowire_eeprom #(
  parameter int PAGE_W    = 3,
  parameter int WC_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] cs_strap,
  output logic       sda_oe
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int DEPTH = 256;
  localparam int WCW   = $clog2(WC_CYCLES + 1);

  localparam logic [2:0] S_IDLE = 3'd0, S_DEV = 3'd1, S_ADDR = 3'd2,
                         S_WDATA = 3'd3, S_RD = 3'd4;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic       scl_s, sda_s;
  logic       start, stop, scl_rise, scl_fall;

  assign scl_s    = scl_sy[1];
  assign sda_s    = sda_sy[1];
  assign start    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop     = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end

  logic [2:0]      st;
  logic [3:0]      cnt;
  logic [7:0]      sr, tx, addr;
  logic            ack_ph;
  logic [PAGE-1:0] pval;
  logic [WCW-1:0]  wc_cnt;
  logic [7:0]      mem  [DEPTH];
  logic [7:0]      pbuf [PAGE];

  logic busy, page_any, dev_hit, wr_byte, commit;
  logic [7:0] rd_byte;

  assign busy     = wc_cnt != '0;
  assign page_any = |pval;
  assign dev_hit  = sr[7:4] == 4'b1010 && sr[3:1] == cs_strap && !busy;
  assign wr_byte  = st == S_WDATA && scl_fall && cnt == 4'd8 && !ack_ph && !start && !stop;
  assign commit   = stop && page_any;
  assign rd_byte  = mem[addr];

  always_ff @(posedge clk)
    if (wr_byte) pbuf[addr[PAGE_W-1:0]] <= sr;

  always_ff @(posedge clk)
    if (commit)
      for (int i = 0; i < PAGE; i++)
        if (pval[i]) mem[{addr[7:PAGE_W], PAGE_W'(i)}] <= pbuf[i];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sr <= '0; tx <= '0; addr <= '0;
      ack_ph <= 1'b0; pval <= '0; wc_cnt <= '0; sda_oe <= 1'b0;
    end else begin
      if (busy) wc_cnt <= wc_cnt - 1'b1;
      if (start) begin
        st <= S_DEV; cnt <= '0; ack_ph <= 1'b0; sda_oe <= 1'b0; pval <= '0;
      end else if (stop) begin
        st <= S_IDLE; ack_ph <= 1'b0; sda_oe <= 1'b0;
        if (page_any) begin
          wc_cnt <= WCW'(WC_CYCLES);
          pval   <= '0;
        end
      end else begin
        case (st)
          S_DEV, S_ADDR, S_WDATA: begin
            if (scl_rise && cnt < 4'd8) begin
              sr  <= {sr[6:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8 && !ack_ph) begin
              if (st == S_DEV && !dev_hit) st <= S_IDLE;
              else begin
                sda_oe <= 1'b1;
                ack_ph <= 1'b1;
                if (st == S_ADDR) addr <= sr;
                if (st == S_WDATA) begin
                  pval[addr[PAGE_W-1:0]] <= 1'b1;
                  addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
                end
              end
            end else if (scl_fall && ack_ph) begin
              ack_ph <= 1'b0;
              cnt    <= '0;
              sda_oe <= 1'b0;
              if (st == S_DEV && sr[0]) begin
                st     <= S_RD;
                tx     <= rd_byte;
                sda_oe <= ~rd_byte[7];
                addr   <= addr + 1'b1;
              end else if (st == S_DEV) st <= S_ADDR;
              else if (st == S_ADDR) st <= S_WDATA;
            end
          end
          S_RD: begin
            if (scl_rise && cnt < 4'd8) cnt <= cnt + 1'b1;
            else if (scl_rise && cnt == 4'd8) begin
              if (sda_s) st <= S_IDLE;
              else cnt <= 4'd9;
            end else if (scl_fall && cnt != 4'd0 && cnt < 4'd8) begin
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
            end else if (scl_fall && cnt == 4'd8) sda_oe <= 1'b0;
            else if (scl_fall && cnt == 4'd9) begin
              tx     <= rd_byte;
              sda_oe <= ~rd_byte[7];
              addr   <= addr + 1'b1;
              cnt    <= '0;
            end
          end
          default: ;
        endcase
      end
    end
endmodule

module twowire_eeprom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       stop,
  input logic       scl_rise,
  input logic       sda_s,
  input logic       busy,
  input logic       page_any,
  input logic       ack_ph,
  input logic       sda_oe,
  input logic [2:0] st,
  input logic [3:0] cnt
);
  localparam logic [2:0] C_IDLE = 3'd0, C_DEV = 3'd1, C_RD = 3'd4;

  AST_START_TO_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> st == C_DEV && cnt == 4'd0); // R1
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> st == C_IDLE && !sda_oe); // R1
  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_DEV && ack_ph) |-> !busy); // R5
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop)); // R5
  AST_NACK_ENDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_RD && scl_rise && cnt == 4'd8 && sda_s) |=> st == C_IDLE && !sda_oe); // R7
  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd9); // R6
  AST_START_DROPS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !page_any); // R9
endmodule

bind twowire_eeprom twowire_eeprom_chk u_chk (.*);

// File: tb/sim_twowire_eeprom.sv
`timescale 1ns/1ps
module sim_twowire_eeprom;
  localparam int WC = 600;
  localparam int Q  = 10;
  localparam logic [7:0] DEV_W = 8'hAA, DEV_R = 8'hAB;
  localparam logic [15:0] VEC [8] = '{16'h803C, 16'h91A7, 16'hA25E, 16'hB301,
                                      16'hC4FE, 16'hD580, 16'hE67F, 16'hF7C3};

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] wd [16];
  logic [7:0] rd [16];

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  twowire_eeprom #(.PAGE_W(3), .WC_CYCLES(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .cs_strap(3'b101), .sda_oe(sda_oe));

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask
  task automatic wbit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic rbit(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); b = sda_bus; tick(Q); scl_m = 1'b0; tick(Q);
  endtask
  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask
  task automatic rbyte(output logic [7:0] d, input logic more);
    logic b;
    for (int i = 0; i < 8; i++) begin rbit(b); d = {d[6:0], b}; end
    wbit(~more);
  endtask

  task automatic write_page(input logic [7:0] a, input int n, input string tag);
    logic ack;
    bus_start;
    wbyte(DEV_W, ack); chk({tag, " dev ack"}, {7'd0, ack}, 8'd1);
    wbyte(a, ack);     chk({tag, " addr ack"}, {7'd0, ack}, 8'd1);
    for (int i = 0; i < n; i++) begin
      wbyte(wd[i], ack); chk({tag, " data ack"}, {7'd0, ack}, 8'd1);
    end
    bus_stop;
    tick(WC + 100);
  endtask
  task automatic read_cur(input int n);
    logic ack;
    bus_start;
    wbyte(DEV_R, ack); chk("R6 read dev ack", {7'd0, ack}, 8'd1);
    for (int i = 0; i < n; i++) rbyte(rd[i], i != n - 1);
    bus_stop;
  endtask
  task automatic read_at(input logic [7:0] a, input int n);
    logic ack;
    bus_start;
    wbyte(DEV_W, ack);
    wbyte(a, ack);
    read_cur(n);
  endtask

  initial begin
    logic ack;
    tick(3);
    chk("R10 reset release", {7'd0, sda_oe}, 8'd0);
    rst_n = 1'b1;
    tick(10);
    chk("R10 idle bus", {7'd0, sda_bus}, 8'd1);

    for (int k = 0; k < 8; k++) begin
      wd[0] = VEC[k][7:0];
      write_page(VEC[k][15:8], 1, "R3");
      read_at(VEC[k][15:8], 1);
      chk("R3 readback", rd[0], VEC[k][7:0]);
    end

    for (int i = 0; i < 10; i++) wd[i] = 8'h20 + 8'(i);
    write_page(8'h10, 10, "R3 burst");
    read_cur(6);
    for (int i = 0; i < 6; i++) chk("R8 next after burst", rd[i], 8'h22 + 8'(i));
    read_at(8'h10, 2);
    chk("R4 overwrite slot0", rd[0], 8'h28);
    chk("R4 overwrite slot1", rd[1], 8'h29);

    wd[0] = 8'h61; wd[1] = 8'h62; wd[2] = 8'h63;
    write_page(8'h16, 3, "R4");
    read_at(8'h10, 1);
    chk("R4 page wrap", rd[0], 8'h63);
    read_at(8'h16, 2);
    chk("R4 slot6", rd[0], 8'h61);
    chk("R4 slot7", rd[1], 8'h62);

    wd[0] = 8'h5A; write_page(8'hFF, 1, "R3");
    wd[0] = 8'hA5; wd[1] = 8'h3C; write_page(8'h00, 2, "R3");
    read_at(8'hFF, 2);
    chk("R6 byte at 255", rd[0], 8'h5A);
    chk("R7 wrap to 0", rd[1], 8'hA5);
    read_cur(1);
    chk("R7 counter after read", rd[0], 8'h3C);

    wd[0] = 8'h01; wd[1] = 8'h02; wd[2] = 8'h03;
    write_page(8'h40, 3, "R3");
    bus_start;
    wbyte(DEV_W, ack); wbyte(8'h40, ack); wbyte(8'h11, ack); wbyte(8'h22, ack);
    wbit(1'b0); wbit(1'b0); wbit(1'b1); wbit(1'b1);
    read_at(8'h40, 3);
    tick(WC + 100);
    read_at(8'h40, 3);
    chk("R9 abort keeps 0x40", rd[0], 8'h01);
    chk("R9 abort keeps 0x41", rd[1], 8'h02);
    chk("R9 abort keeps 0x42", rd[2], 8'h03);

    bus_start;
    wbyte(8'hA0, ack); chk("R2 strap mismatch nack", {7'd0, ack}, 8'd0);
    wbyte(8'h40, ack); chk("R2 ignored after mismatch", {7'd0, ack}, 8'd0);
    bus_stop;
    bus_start;
    wbyte(8'hBA, ack); chk("R2 family mismatch nack", {7'd0, ack}, 8'd0);
    bus_stop;

    wd[0] = 8'h77;
    bus_start;
    wbyte(DEV_W, ack); wbyte(8'h50, ack); wbyte(wd[0], ack);
    bus_stop;
    bus_start;
    wbyte(DEV_W, ack); chk("R5 busy nack", {7'd0, ack}, 8'd0);
    bus_stop;
    tick(WC + 100);
    bus_start;
    wbyte(DEV_W, ack); chk("R5 ack after busy", {7'd0, ack}, 8'd1);
    wbyte(8'h50, ack);
    read_cur(1);
    chk("R3 committed 0x50", rd[0], 8'h77);

    read_at(8'h12, 1);
    bus_start;
    wbyte(DEV_R, ack);
    tick(4);
    chk("R6 drives data low", {7'd0, sda_oe}, 8'd1);
    rst_n = 1'b0; tick(3);
    chk("R10 reset mid read", {7'd0, sda_oe}, 8'd0);
    scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b1; tick(20);
    read_at(8'h13, 1);
    chk("R10 operational after reset", rd[0], 8'h23);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule